// File: doc/BRIEF.md
# SPI FIFO DMA Request Generator

This block sits beside the transmit and receive FIFOs of an SPI master. It watches the fill level of each FIFO and raises DMA request lines when the levels cross programmable watermarks. There are three request lines. The transmit line asks for more data when the TX FIFO runs low. The receive line asks for a drain when the RX FIFO fills. A third tail line has its own watermark and its own enable. It lets the last few words of a transfer drain by DMA once the burst has ended, even when the transfer length is not a multiple of the burst size. Software sets all three watermarks to half the FIFO depth. For an odd-sized transfer it lowers the tail watermark to the remainder, then restores it after the transfer.

The block also decides when an exchange starts. Software can write a one-cycle start strobe. It can also select a start-on-write mode, in which an exchange begins as soon as the TX FIFO holds data. It clears that mode when DMA is done. Registers are written through a simple single-cycle write port. They are read back combinationally.

Top module: `spi_dma_req_gen`

## Requirements
- R1: After reset, the control word (offset 0x08), the DMA word (offset 0x14) and the status word (offset 0x18) all read zero, and all four outputs are low.
- R2: The DMA word holds three 6-bit watermarks and three request enables: TX watermark in bits [5:0] with enable in bit 7, RX watermark in [21:16] with enable in 23, tail watermark in [29:24] with enable in 31. Every other bit reads back zero, so writing all ones reads 0xBFBF00BF.
- R3: While the TX enable is set, tx_dma_req is high exactly when tx_level is at or below the TX watermark, compared as unsigned integers.
- R4: While the RX enable is set, rx_dma_req is high exactly when rx_level is at or above the RX watermark, compared as unsigned integers.
- R5: While the tail enable is set, tail_dma_req is high exactly when burst_idle is high and rx_level is at or above the tail watermark.
- R6: A request whose enable bit is clear stays low for every FIFO level and watermark.
- R7: In the control word, bit 0 enables the block, bit 2 is the start strobe and bit 3 selects start-on-write. The status word reads {tail_dma_req, rx_dma_req, tx_dma_req} in bits [2:0] and zero elsewhere. Writes to the status word change nothing.
- R8: Writing the control word with bits 0 and 2 set raises xch_go for exactly the one cycle after the write. The strobe bit then reads back zero.
- R9: With the block enabled and start-on-write set, xch_go is high whenever tx_level is non-zero. Clearing start-on-write drops it.
- R10: With control bit 0 clear, xch_go stays low, whatever the strobe, the mode or the TX level.
- R11: Writes to offsets other than 0x08 and 0x14 leave every register and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tx_level | input | LVL_W | Words held in the TX FIFO |
| rx_level | input | LVL_W | Words held in the RX FIFO |
| burst_idle | input | 1 | High when the current burst has ended |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| tail_dma_req | output | 1 | RX-tail DMA request |
| xch_go | output | 1 | Exchange start to the shift engine |

## Verification
The assertions assume a few things about the inputs. The FIFO levels never exceed DEPTH. Reset is held for at least one clock edge before any register write. burst_idle may change in any cycle, so no property relies on it staying steady. The bench changes levels and burst_idle only between edges. It keeps levels within 0 to DEPTH, and it writes registers only after reset is released. It sweeps every watermark against every legal level.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
    localparam int WM_W = 6;
    localparam int NCH  = 3;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_DMA  = 8'h14;
    localparam logic [7:0] OFS_STAT = 8'h18;

    typedef struct packed {
        logic [WM_W-1:0] wm;
        logic            en;
    } chan_cfg_t;

    typedef struct packed {
        logic blk_en;
        logic strobe;
        logic wr_start;
    } ctrl_t;

    typedef struct packed {
        ctrl_t                    ctrl;
        chan_cfg_t [NCH-1:0]      ch;
    } reg_state_t;

    // channel 0 = TX, 1 = RX, 2 = tail; watermark lsb in the DMA word
    function automatic int wm_lsb(input int c);
        return (c == 0) ? 0 : 8 * c + 8;
    endfunction

    function automatic int en_bit(input int c);
        return wm_lsb(c) + 7;
    endfunction
endpackage

// File: rtl/spi_dma_regs.sv
module spi_dma_regs
    import spi_dma_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [AW-1:0]         addr,
    input  logic [31:0]           wdata,
    input  logic [NCH-1:0]        stat_in,
    output logic [31:0]           rdata,
    output chan_cfg_t [NCH-1:0]   cfg,
    output ctrl_t                 ctrl
);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_DMA  = AW'(OFS_DMA);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.ctrl.strobe = 1'b0;
        if (wr && addr == A_CTRL) begin
            st_d.ctrl.blk_en   = wdata[0];
            st_d.ctrl.strobe   = wdata[2];
            st_d.ctrl.wr_start = wdata[3];
        end
        if (wr && addr == A_DMA) begin
            for (int c = 0; c < NCH; c++) begin
                st_d.ch[c].wm = wdata[wm_lsb(c) +: WM_W];
                st_d.ch[c].en = wdata[en_bit(c)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[0] = st_q.ctrl.blk_en;
            rdata[2] = st_q.ctrl.strobe;
            rdata[3] = st_q.ctrl.wr_start;
        end else if (addr == A_DMA) begin
            for (int c = 0; c < NCH; c++) begin
                rdata[wm_lsb(c) +: WM_W] = st_q.ch[c].wm;
                rdata[en_bit(c)]         = st_q.ch[c].en;
            end
        end else if (addr == A_STAT) begin
            rdata[NCH-1:0] = stat_in;
        end
    end

    assign cfg  = st_q.ch;
    assign ctrl = st_q.ctrl;

    AST_STROBE_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctrl.strobe && !(wr && addr == A_CTRL && wdata[2])) |=> !st_q.ctrl.strobe) // R8
        else $error("strobe did not self-clear");

    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_STAT) |=> $stable(st_q)) // R11
        else $error("status write changed state");
endmodule

// File: rtl/spi_dma_req.sv
module spi_dma_req
    import spi_dma_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  chan_cfg_t [NCH-1:0]   cfg,
    input  logic [LVL_W-1:0]      tx_level,
    input  logic [LVL_W-1:0]      rx_level,
    input  logic                  burst_idle,
    output logic [NCH-1:0]        req
);
    localparam int CW = (LVL_W > WM_W) ? LVL_W : WM_W;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CW-1:0] wm_x;
        assign wm_x = CW'(cfg[c].wm);
        if (c == 0) begin : g_tx
            assign req[c] = cfg[c].en && (CW'(tx_level) <= wm_x);
        end else if (c == 1) begin : g_rx
            assign req[c] = cfg[c].en && (CW'(rx_level) >= wm_x);
        end else begin : g_tail
            assign req[c] = cfg[c].en && burst_idle && (CW'(rx_level) >= wm_x);
        end
    end

    AST_TAIL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !burst_idle |-> !req[2]) // R5
        else $error("tail request during burst");

    AST_TX_EMPTY_REQ: assert property (@(posedge clk) disable iff (rst)
        (cfg[0].en && tx_level == '0) |-> req[0]) // R3
        else $error("tx request missing with empty fifo");
endmodule

// File: rtl/spi_dma_start.sv
module spi_dma_start
    import spi_dma_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  ctrl_t             ctrl,
    input  logic [LVL_W-1:0]  tx_level,
    output logic              xch_go
);
    logic tx_has_data;
    assign tx_has_data = (tx_level != '0);
    assign xch_go = ctrl.blk_en && (ctrl.strobe || (ctrl.wr_start && tx_has_data));
endmodule

// File: rtl/spi_dma_req_gen.sv
module spi_dma_req_gen
    import spi_dma_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              burst_idle,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              tail_dma_req,
    output logic              xch_go
);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_DMA  = AW'(OFS_DMA);

    chan_cfg_t [NCH-1:0] cfg;
    ctrl_t               ctrl;
    logic [NCH-1:0]      req;

    spi_dma_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .stat_in(req), .rdata(reg_rdata), .cfg(cfg), .ctrl(ctrl)
    );

    spi_dma_req #(.LVL_W(LVL_W)) u_req (
        .clk(clk), .rst(rst), .cfg(cfg), .tx_level(tx_level), .rx_level(rx_level),
        .burst_idle(burst_idle), .req(req)
    );

    spi_dma_start #(.LVL_W(LVL_W)) u_start (
        .ctrl(ctrl), .tx_level(tx_level), .xch_go(xch_go)
    );

    assign tx_dma_req   = req[0];
    assign rx_dma_req   = req[1];
    assign tail_dma_req = req[2];

    AST_TX_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_DMA && !reg_wdata[7]) |=> !tx_dma_req) // R6
        else $error("tx request while disabled");

    AST_RX_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_DMA && !reg_wdata[23]) |=> !rx_dma_req) // R6
        else $error("rx request while disabled");

    AST_TAIL_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_DMA && !reg_wdata[31]) |=> !tail_dma_req) // R6
        else $error("tail request while disabled");

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[0]) |=> !xch_go) // R10
        else $error("start while block disabled");

    AST_STROBE_START: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[0] && reg_wdata[2]) |=> xch_go) // R8
        else $error("strobe gave no start");
endmodule

// File: tb/sim_spi_dma_req_gen.sv
module sim_spi_dma_req_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [LVL_W-1:0] tx_level = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic burst_idle = 1'b0;
    logic tx_dma_req, rx_dma_req, tail_dma_req, xch_go;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_dma_req_gen #(.DEPTH(DEPTH), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
        .rx_level(rx_level), .burst_idle(burst_idle), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req), .tail_dma_req(tail_dma_req), .xch_go(xch_go)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] dma_word(input bit txe, input int txw, input bit rxe,
                                             input int rxw, input bit tle, input int tlw);
        return {tle, 1'b0, 6'(tlw), rxe, 1'b0, 6'(rxw), 8'h00, txe, 1'b0, 6'(txw)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h08, r); chk("R1 ctrl", r, 32'h0);
        rd(8'h14, r); chk("R1 dma", r, 32'h0);
        rd(8'h18, r); chk("R1 stat", r, 32'h0);
        chk("R1 outs", {28'h0, tx_dma_req, rx_dma_req, tail_dma_req, xch_go}, 32'h0);

        // R2 layout
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, r); chk("R2 ones", r, 32'hBFBF_00BF);
        wr(8'h14, 32'h4040_FF40);
        rd(8'h14, r); chk("R2 holes", r, 32'h0);

        // R3 tx sweep
        for (int w = 0; w < 64; w++) begin
            wr(8'h14, dma_word(1, w, 0, 0, 0, 0));
            for (int l = 0; l <= DEPTH; l++) begin
                tx_level = LVL_W'(l); #1;
                chk("R3 tx", {31'h0, tx_dma_req}, {31'h0, (l <= w)});
            end
        end
        tx_level = '0;

        // R4 rx and R5 tail sweep, status R7
        for (int w = 0; w < 64; w++) begin
            wr(8'h14, dma_word(0, 0, 1, w, 1, 63 - w));
            for (int l = 0; l <= DEPTH; l++) begin
                for (int b = 0; b < 2; b++) begin
                    rx_level = LVL_W'(l); burst_idle = b[0]; #1;
                    chk("R4 rx", {31'h0, rx_dma_req}, {31'h0, (l >= w)});
                    chk("R5 tail", {31'h0, tail_dma_req}, {31'h0, (b == 1 && l >= 63 - w)});
                    if (l % 16 == 0) begin
                        rd(8'h18, r);
                        chk("R7 stat", r, {29'h0, (b == 1 && l >= 63 - w), (l >= w), 1'b0});
                    end
                end
            end
        end

        // R6 enables clear
        wr(8'h14, dma_word(0, 63, 0, 0, 0, 0));
        burst_idle = 1'b1;
        for (int l = 0; l <= DEPTH; l++) begin
            tx_level = LVL_W'(l); rx_level = LVL_W'(l); #1;
            chk("R6 off", {29'h0, tx_dma_req, rx_dma_req, tail_dma_req}, 32'h0);
        end
        tx_level = '0;

        // R8 strobe
        wr(8'h08, 32'h0000_0005);
        chk("R8 go", {31'h0, xch_go}, 32'h1);
        rd(8'h08, r); chk("R7 ctrl strobe", r, 32'h5);
        @(negedge clk);
        chk("R8 selfclr", {31'h0, xch_go}, 32'h0);
        rd(8'h08, r); chk("R8 ctrl rb", r, 32'h1);

        // R9 start-on-write
        wr(8'h08, 32'h0000_0009);
        #1; chk("R9 empty", {31'h0, xch_go}, 32'h0);
        tx_level = LVL_W'(3); #1;
        chk("R9 data", {31'h0, xch_go}, 32'h1);
        tx_level = LVL_W'(DEPTH); #1;
        chk("R9 full", {31'h0, xch_go}, 32'h1);
        wr(8'h08, 32'h0000_0001);
        chk("R9 clear", {31'h0, xch_go}, 32'h0);

        // R10 block disabled
        wr(8'h08, 32'h0000_0004);
        chk("R10 strobe", {31'h0, xch_go}, 32'h0);
        wr(8'h08, 32'h0000_000C);
        chk("R10 mode", {31'h0, xch_go}, 32'h0);
        @(negedge clk);
        chk("R10 later", {31'h0, xch_go}, 32'h0);

        // R11 other offsets ignored
        wr(8'h08, 32'h0000_0001);
        wr(8'h14, dma_word(1, 10, 1, 20, 1, 30));
        tx_level = LVL_W'(5); rx_level = LVL_W'(25); burst_idle = 1'b0;
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h14, r); chk("R11 dma", r, dma_word(1, 10, 1, 20, 1, 30));
        rd(8'h08, r); chk("R11 ctrl", r, 32'h1);
        chk("R11 outs", {28'h0, tx_dma_req, rx_dma_req, tail_dma_req, xch_go}, 32'hC);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule